// File: doc/BRIEF.md
# Stop-Clock Request Sequencer

This block turns an asynchronous, active-low request to stop the core clock into an ordered shutdown of execution. The request is first brought into the core clock domain. After that the block waits for an instruction boundary at which no higher-priority interrupt is pending, and it halts execution at that boundary. It then holds a drain request until both the pipelines and the write buffers report empty. Finally it raises a request for exactly one stop-grant acknowledge bus cycle.

Once the bus side reports that cycle complete, the block sits in a stopped state. It stays there until the synchronised request goes inactive, and then it returns to idle. The system may release the request only after the grant cycle has gone out. If the request is released earlier, the block raises a sticky protocol-error flag but still finishes the grant cycle. The flag clears when the block goes back to idle. Clock gating and the encoding of the bus cycle are handled elsewhere.

Top module: `stop_clock_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, halt_exec, drain_req, grant_req, stopped and proto_err are all 0.
- R2: A low level on stop_req_n passes through SYNC_STAGES flops. The block leaves idle on the clock edge that follows, so halt_exec can rise no earlier than SYNC_STAGES+2 edges after the request is driven low.
- R3: While the block waits for a boundary, a cycle with insn_boundary=1 and hi_irq_pend=0 makes halt_exec and drain_req go to 1 on the next edge. Cycles without insn_boundary leave them at 0.
- R4: A boundary cycle with hi_irq_pend=1 does not halt. The stop is deferred to a later boundary at which hi_irq_pend=0.
- R5: drain_req stays 1 until pipe_empty=1 and wbuf_empty=1 in the same cycle. If only one of them is 1, the block keeps draining. On the edge after both are 1, drain_req goes to 0 and grant_req goes to 1.
- R6: grant_req stays 1 until bus_done=1. On the next edge grant_req goes to 0 and stopped goes to 1. grant_req does not rise again while stopped is 1, so each request produces one grant.
- R7: stopped stays 1 while the request is held. Once stop_req_n has been high for SYNC_STAGES edges, the following edge clears stopped and halt_exec.
- R8: If the synchronised request goes inactive while the block is waiting, draining or granting, proto_err goes to 1 on the next edge. The sequence still runs through the grant cycle, and proto_err goes back to 0 on the same edge at which stopped falls.
- R9: halt_exec is 1 whenever drain_req, grant_req or stopped is 1. At most one of drain_req, grant_req and stopped is 1 at a time.
- R10: After a return to idle, a new request runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| stop_req_n | input | 1 | Asynchronous stop-clock request, active low |
| insn_boundary | input | 1 | Strobe that marks an instruction boundary |
| hi_irq_pend | input | 1 | A higher-priority interrupt is pending |
| pipe_empty | input | 1 | Internal pipelines are empty |
| wbuf_empty | input | 1 | Write buffers are empty |
| bus_done | input | 1 | The requested stop-grant bus cycle has completed |
| halt_exec | output | 1 | Execution is halted |
| drain_req | output | 1 | Request to drain the pipelines and write buffers |
| grant_req | output | 1 | Request for the stop-grant acknowledge bus cycle |
| stopped | output | 1 | Grant has been issued and the core is stopped |
| proto_err | output | 1 | Request was withdrawn before the grant completed |

## Verification
The bench builds the block with SYNC_STAGES set to 2 and derives every latency from that localparam. This lets it check the exact edge at which the request is seen and the exact edge at which a release takes effect. With a short synchroniser, a release made during the drain phase lands while the block is still draining. That makes the protocol-error path reachable, along with its clearing on the way back to idle.

// File: rtl/stpc_pkg.sv
package stpc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_BND = 3'd1,
        ST_DRAIN    = 3'd2,
        ST_GRANT    = 3'd3,
        ST_STOPPED  = 3'd4
    } stpc_state_t;

    typedef struct packed {
        logic halt;
        logic drain;
        logic grant;
        logic stopped;
    } stpc_out_t;

    function automatic logic stpc_in_flight(stpc_state_t s);
        return (s == ST_WAIT_BND) || (s == ST_DRAIN) || (s == ST_GRANT);
    endfunction

    function automatic stpc_out_t stpc_decode(stpc_state_t s);
        stpc_out_t o;
        o.halt    = (s == ST_DRAIN) || (s == ST_GRANT) || (s == ST_STOPPED);
        o.drain   = (s == ST_DRAIN);
        o.grant   = (s == ST_GRANT);
        o.stopped = (s == ST_STOPPED);
        return o;
    endfunction

endpackage

// File: rtl/stpc_sync.sv
module stpc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic level_active
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= async_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign level_active = ~chain[STAGES-1];
endmodule

// File: rtl/stpc_fsm.sv
module stpc_fsm
    import stpc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic        insn_boundary,
    input  logic        hi_irq_pend,
    input  logic        pipe_empty,
    input  logic        wbuf_empty,
    input  logic        bus_done,
    output stpc_state_t state
);
    stpc_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (req) nxt = ST_WAIT_BND;
            ST_WAIT_BND: if (insn_boundary && !hi_irq_pend) nxt = ST_DRAIN;
            ST_DRAIN:    if (pipe_empty && wbuf_empty) nxt = ST_GRANT;
            ST_GRANT:    if (bus_done) nxt = ST_STOPPED;
            ST_STOPPED:  if (!req) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/stpc_err.sv
module stpc_err
    import stpc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  stpc_state_t state,
    output logic        err
);
    always_ff @(posedge clk) begin
        if (rst)
            err <= 1'b0;
        else if (state == ST_STOPPED && !req)
            err <= 1'b0;
        else if (stpc_in_flight(state) && !req)
            err <= 1'b1;
    end
endmodule

// File: rtl/stop_clock_seq.sv
module stop_clock_seq
    import stpc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic stop_req_n,
    input  logic insn_boundary,
    input  logic hi_irq_pend,
    input  logic pipe_empty,
    input  logic wbuf_empty,
    input  logic bus_done,
    output logic halt_exec,
    output logic drain_req,
    output logic grant_req,
    output logic stopped,
    output logic proto_err
);
    logic        req_seen;
    stpc_state_t state;
    stpc_out_t   outs;

    stpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst          (rst),
        .async_n      (stop_req_n),
        .level_active (req_seen)
    );

    stpc_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .req           (req_seen),
        .insn_boundary (insn_boundary),
        .hi_irq_pend   (hi_irq_pend),
        .pipe_empty    (pipe_empty),
        .wbuf_empty    (wbuf_empty),
        .bus_done      (bus_done),
        .state         (state)
    );

    stpc_err u_err (
        .clk   (clk),
        .rst   (rst),
        .req   (req_seen),
        .state (state),
        .err   (proto_err)
    );

    assign outs      = stpc_decode(state);
    assign halt_exec = outs.halt;
    assign drain_req = outs.drain;
    assign grant_req = outs.grant;
    assign stopped   = outs.stopped;
endmodule

// File: rtl/stpc_chk.sv
module stpc_chk (
    input logic clk,
    input logic rst,
    input logic insn_boundary,
    input logic hi_irq_pend,
    input logic pipe_empty,
    input logic wbuf_empty,
    input logic bus_done,
    input logic halt_exec,
    input logic drain_req,
    input logic grant_req,
    input logic stopped,
    input logic proto_err
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> !(halt_exec || drain_req || grant_req || stopped || proto_err));

    assert_halt_at_clean_boundary_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(drain_req) |-> $past(insn_boundary && !hi_irq_pend));

    assert_grant_after_empty_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_req) |-> $past(drain_req && pipe_empty && wbuf_empty));

    assert_grant_held_R6: assert property (@(posedge clk) disable iff (rst)
        grant_req && !bus_done |=> grant_req);

    assert_grant_single_R6: assert property (@(posedge clk) disable iff (rst)
        grant_req && bus_done |=> stopped && !grant_req);

    assert_err_clears_on_exit_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(stopped) |-> !proto_err);

    assert_halt_covers_R9: assert property (@(posedge clk) disable iff (rst)
        (drain_req || grant_req || stopped) |-> halt_exec);

    assert_phase_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({drain_req, grant_req, stopped}));
endmodule

bind stop_clock_seq stpc_chk u_stpc_chk (
    .clk           (clk),
    .rst           (rst),
    .insn_boundary (insn_boundary),
    .hi_irq_pend   (hi_irq_pend),
    .pipe_empty    (pipe_empty),
    .wbuf_empty    (wbuf_empty),
    .bus_done      (bus_done),
    .halt_exec     (halt_exec),
    .drain_req     (drain_req),
    .grant_req     (grant_req),
    .stopped       (stopped),
    .proto_err     (proto_err)
);

// File: tb/tb_stop_clock_seq.sv
module tb_stop_clock_seq;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_req_n = 1'b1, insn_boundary = 1'b0, hi_irq_pend = 1'b0;
    logic pipe_empty = 1'b0, wbuf_empty = 1'b0, bus_done = 1'b0;
    logic halt_exec, drain_req, grant_req, stopped, proto_err;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stop_clock_seq #(.SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst(rst), .stop_req_n(stop_req_n),
        .insn_boundary(insn_boundary), .hi_irq_pend(hi_irq_pend),
        .pipe_empty(pipe_empty), .wbuf_empty(wbuf_empty), .bus_done(bus_done),
        .halt_exec(halt_exec), .drain_req(drain_req), .grant_req(grant_req),
        .stopped(stopped), .proto_err(proto_err)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: {halt,drain,grant,stopped,err} actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [4:0] obs();
        return {halt_exec, drain_req, grant_req, stopped, proto_err};
    endfunction

    task automatic bring_to_drain();
        stop_req_n = 1'b0; insn_boundary = 1'b1; hi_irq_pend = 1'b0;
        tick(SYNC + 2);
    endtask

    task automatic finish_and_release(input string req);
        pipe_empty = 1'b1; wbuf_empty = 1'b1;
        tick();
        pipe_empty = 1'b0; wbuf_empty = 1'b0;
        bus_done = 1'b1;
        tick();
        bus_done = 1'b0;
        stop_req_n = 1'b1;
        tick(SYNC + 1);
        chk(req, obs(), 5'b00000);
    endtask

    task automatic t_reset();
        tick(2);
        chk("R1 in reset", obs(), 5'b00000);
        rst = 1'b0;
        tick();
        chk("R1 after reset", obs(), 5'b00000);
    endtask

    task automatic t_basic();
        stop_req_n = 1'b0; insn_boundary = 1'b1;
        tick(SYNC + 1);
        chk("R2 not yet halted", obs(), 5'b00000);
        tick();
        chk("R2 R3 halt at boundary", obs(), 5'b11000);
        insn_boundary = 1'b0;
        pipe_empty = 1'b1; wbuf_empty = 1'b1;
        tick();
        chk("R5 grant after drain", obs(), 5'b10100);
        pipe_empty = 1'b0; wbuf_empty = 1'b0;
        tick(3);
        chk("R6 grant held", obs(), 5'b10100);
        bus_done = 1'b1;
        tick();
        bus_done = 1'b0;
        chk("R6 stopped after done", obs(), 5'b10010);
        tick(4);
        chk("R6 R7 one grant, stays stopped", obs(), 5'b10010);
        stop_req_n = 1'b1;
        tick(SYNC);
        chk("R7 still stopped during sync", obs(), 5'b10010);
        tick();
        chk("R7 back to idle", obs(), 5'b00000);
    endtask

    task automatic t_irq_priority();
        stop_req_n = 1'b0; insn_boundary = 1'b0; hi_irq_pend = 1'b1;
        tick(SYNC + 1);
        tick(3);
        chk("R3 no boundary no halt", obs(), 5'b00000);
        insn_boundary = 1'b1;
        tick(3);
        chk("R4 irq defers stop", obs(), 5'b00000);
        hi_irq_pend = 1'b0;
        tick();
        chk("R4 halt at later clean boundary", obs(), 5'b11000);
        insn_boundary = 1'b0;
        finish_and_release("R4 sequence completes");
    endtask

    task automatic t_drain_order();
        bring_to_drain();
        insn_boundary = 1'b0;
        pipe_empty = 1'b1; wbuf_empty = 1'b0;
        tick(2);
        chk("R5 pipe empty only", obs(), 5'b11000);
        pipe_empty = 1'b0; wbuf_empty = 1'b1;
        tick(2);
        chk("R5 wbuf empty only", obs(), 5'b11000);
        pipe_empty = 1'b1;
        tick();
        chk("R5 both empty -> grant", obs(), 5'b10100);
        pipe_empty = 1'b0; wbuf_empty = 1'b0;
        bus_done = 1'b1;
        tick();
        bus_done = 1'b0;
        stop_req_n = 1'b1;
        tick(SYNC + 1);
        chk("R5 return idle", obs(), 5'b00000);
    endtask

    task automatic t_withdraw();
        bring_to_drain();
        insn_boundary = 1'b0;
        chk("R8 draining, no error yet", obs(), 5'b11000);
        stop_req_n = 1'b1;
        tick(SYNC);
        chk("R8 error not before sync", obs(), 5'b11000);
        tick();
        chk("R8 error raised, still draining", obs(), 5'b11001);
        pipe_empty = 1'b1; wbuf_empty = 1'b1;
        tick();
        pipe_empty = 1'b0; wbuf_empty = 1'b0;
        chk("R8 grant still issued", obs(), 5'b10101);
        bus_done = 1'b1;
        tick();
        bus_done = 1'b0;
        chk("R8 stopped with error", obs(), 5'b10011);
        tick();
        chk("R8 error clears with stopped", obs(), 5'b00000);
    endtask

    task automatic t_restart();
        bring_to_drain();
        insn_boundary = 1'b0;
        chk("R10 second request halts", obs(), 5'b11000);
        finish_and_release("R10 second sequence completes");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_irq_priority();
        t_drain_order();
        t_withdraw();
        t_restart();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            total++;
            bad++;
            done = 1'b1;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule